// File: doc/BRIEF.md
# Saturating Counter Receive Glitch Filter

This block cleans up one serial receive line coming from a bus transceiver before the line reaches a symbol decoder. The raw line may be asynchronous to the filter clock, so it first passes through a short chain of synchronizing flops. The synchronized sample then steers an up/down counter that saturates at zero and at its top value: a 1 sample counts up and a 0 sample counts down.

The filtered output is held in a latch that changes state only when the counter arrives at an end point. It goes high at the top value and low at zero. Every counter value in between leaves it alone, which gives hysteresis. A pulse too short to walk the counter from one end to the other never appears at the output. Noise during a real transition delays that transition rather than doubling it.

A one-cycle strobe marks each change of the filtered output, so a downstream timer can start on it. Reset puts the filter in the idle, recessive state with the output high.

Top module: `rxf_glitch_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is `rx_out` = 1 and `rx_edge` = 0, with the counter full and the synchronizer stages holding 1. After reset, a 14-cycle low pulse on `rx_in` leaves `rx_out` at 1.
- R2: At every clock, a synchronized sample of 1 raises the counter by one and a sample of 0 lowers it by one. The counter stays put at the end it would otherwise pass.
- R3: `rx_out` becomes 1 on the clock after the counter reaches its top value (15 with the default 4-bit counter). It becomes 0 on the clock after the counter reaches 0.
- R4: The counter never wraps. After a long run of 1s, exactly 15 low samples are enough to drive `rx_out` low. After a long run of 0s, exactly 15 high samples are enough to drive it high.
- R5: While the counter sits strictly between 0 and its top value, `rx_out` keeps its value. Two 10-cycle low pulses separated by 3 high cycles therefore still drive `rx_out` low, because the counter only recovers part of the way in between.
- R6: A change of `rx_in` that is first sampled at rising edge k appears on `rx_out` right after edge k+17. That is 2 synchronizer stages plus 15 counter steps, with the 15 steps ending in the output latch. Relative to an asynchronous edge, this gives a delay of 17 to 18 clock periods.
- R7: A pulse of fewer than 15 clock periods on `rx_in` does not appear on `rx_out` at all, and `rx_edge` stays 0.
- R8: Each opposing sample that arrives during a real transition delays the output change by 2 cycles. One high sample inside a falling transition moves the change from edge k+17 to edge k+19.
- R9: `rx_edge` is 1 for exactly the one cycle in which `rx_out` differs from its previous value, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Raw receive line from the transceiver, may be asynchronous |
| rx_out | output | 1 | Filtered receive level |
| rx_edge | output | 1 | One-cycle strobe on each change of `rx_out` |

## Verification
The assertions take `rst` as synchronous to `clk`, and they make no assumption about the timing of `rx_in`. The one exception is the check that two strobes never arrive back to back: it relies on the structural fact that the counter needs at least 15 clocks to travel between its ends. The stimulus changes `rx_in` only on falling clock edges, so every sample lands at a known rising edge. This lets the exact arrival edge of each output change be predicted and compared.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Position of the counter relative to its end points.
  typedef enum logic [1:0] {
    LVL_MID  = 2'd0,
    LVL_BOT  = 2'd1,
    LVL_TOP  = 2'd2
  } rxf_lvl_e;

  // Classify a counter value against the top end point.
  function automatic rxf_lvl_e rxf_classify(input int unsigned value,
                                            input int unsigned top);
    if (value == 0)        return LVL_BOT;
    else if (value == top) return LVL_TOP;
    else                   return LVL_MID;
  endfunction

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RESET_VAL;
          else     chain[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= RESET_VAL;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/rxf_sat_cnt.sv
module rxf_sat_cnt
  import rxf_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_i,
  output logic [CNT_W-1:0] cnt_o,
  output rxf_lvl_e         lvl_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_BOT = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (up_i) begin
      if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    end else begin
      if (cnt_q != CNT_BOT) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_TOP;
    else     cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign lvl_o = rxf_classify(int'(cnt_q), int'(CNT_TOP));

  // R4: no wrap at either end
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_TOP && up_i) |=> (cnt_q == CNT_TOP));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_BOT && !up_i) |=> (cnt_q == CNT_BOT));
  // R2: direction follows the sample
  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst)
    up_i |=> (cnt_q >= $past(cnt_q)));
  assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
    !up_i |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/rxf_out_latch.sv
module rxf_out_latch
  import rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  rxf_lvl_e lvl_i,
  output logic     out_o,
  output logic     edge_o
);

  logic out_q;
  logic edge_q;
  logic out_d;

  always_comb begin
    unique case (lvl_i)
      LVL_TOP: out_d = 1'b1;
      LVL_BOT: out_d = 1'b0;
      default: out_d = out_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      edge_q <= (out_d != out_q);
    end
  end

  assign out_o  = out_q;
  assign edge_o = edge_q;

  // R5: intermediate counter values never move the output
  assert_hold_mid_R5: assert property (@(posedge clk) disable iff (rst)
    (lvl_i == LVL_MID) |=> $stable(out_q));
  // R3: end points force the level
  assert_set_top_R3: assert property (@(posedge clk) disable iff (rst)
    (lvl_i == LVL_TOP) |=> out_q);
  assert_clr_bot_R3: assert property (@(posedge clk) disable iff (rst)
    (lvl_i == LVL_BOT) |=> !out_q);
  // R9: strobe marks changes only
  assert_edge_on_change_R9: assert property (@(posedge clk) disable iff (rst)
    (out_q != $past(out_q)) |-> edge_q);
  assert_edge_only_change_R9: assert property (@(posedge clk) disable iff (rst)
    edge_q |-> (out_q != $past(out_q)));

endmodule

// File: rtl/rxf_glitch_filter.sv
module rxf_glitch_filter
  import rxf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_out,
  output logic rx_edge
);

  logic             rx_sync;
  logic [CNT_W-1:0] cnt;
  rxf_lvl_e         lvl;

  rxf_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (rx_in),
    .q_o (rx_sync)
  );

  rxf_sat_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .up_i  (rx_sync),
    .cnt_o (cnt),
    .lvl_o (lvl)
  );

  rxf_out_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (lvl),
    .out_o  (rx_out),
    .edge_o (rx_edge)
  );

  // R9: a swing needs many clocks, so strobes never touch
  assert_edge_single_R9: assert property (@(posedge clk) disable iff (rst)
    rx_edge |=> !rx_edge);
  // R3: output agrees with the counter whenever the counter sits at an end
  assert_out_tracks_end_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> !rx_out);

endmodule

// File: tb/rxf_glitch_filter_tb.sv
module rxf_glitch_filter_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic rx_out;
  logic rx_edge;

  int n_tests = 0;
  int n_fail  = 0;

  logic pat [0:99];
  int   first_fall, first_rise, n_edges, edge_bad;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  rxf_glitch_filter u_dut (
    .clk     (clk),
    .rst     (rst),
    .rx_in   (rx_in),
    .rx_out  (rx_out),
    .rx_edge (rx_edge)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst   = 1'b1;
    rx_in = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill(int lo, int hi, logic v);
    for (int i = lo; i < hi; i++) pat[i] = v;
  endtask

  // Iteration t observes state after edge t, then drives the sample for edge t+1.
  task automatic run(int len);
    logic prev;
    first_fall = -1; first_rise = -1; n_edges = 0; edge_bad = 0;
    prev = rx_out;
    for (int t = 0; t < len; t++) begin
      if (rx_out != prev) begin
        if (!rx_out && first_fall < 0) first_fall = t;
        if (rx_out && first_fall >= 0 && first_rise < 0) first_rise = t;
      end
      if (rx_edge) n_edges++;
      if (rx_edge != (rx_out != prev)) edge_bad++;
      prev  = rx_out;
      rx_in = pat[t];
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 out after reset", int'(rx_out), 1);
    check("R1 edge after reset", int'(rx_edge), 0);
    fill(0, 100, 1'b1); fill(0, 14, 1'b0);
    run(60);
    check("R1 14-cycle pulse after reset no fall", first_fall, -1);
  endtask

  task automatic t_steps();
    do_reset();
    fill(0, 100, 1'b0); fill(40, 100, 1'b1);
    run(80);
    check("R6 falling latency", first_fall, 18);
    check("R6 rising latency", first_rise, 58);
    check("R9 two strobes", n_edges, 2);
    check("R9 strobe aligned", edge_bad, 0);
  endtask

  task automatic t_short_pulse();
    do_reset();
    fill(0, 100, 1'b1); fill(0, 14, 1'b0);
    run(50);
    check("R7 pulse of 14 absent", first_fall, -1);
    check("R7 no strobe", n_edges, 0);
  endtask

  task automatic t_min_pulse();
    do_reset();
    fill(0, 100, 1'b1); fill(0, 15, 1'b0);
    run(60);
    check("R4 15 low samples flip", first_fall, 18);
    check("R4 no underflow rise at 33", first_rise, 33);
    check("R3 strobes on both flips", n_edges, 2);
  endtask

  task automatic t_burst();
    do_reset();
    fill(0, 100, 1'b0); pat[5] = 1'b1;
    run(40);
    check("R8 one opposing sample delays by 2", first_fall, 20);
    check("R9 single strobe", n_edges, 1);
  endtask

  task automatic t_hysteresis();
    do_reset();
    fill(0, 100, 1'b1); fill(0, 10, 1'b0);
    run(40);
    check("R5 partial swing holds", first_fall, -1);
    do_reset();
    fill(0, 100, 1'b1); fill(0, 10, 1'b0); fill(13, 23, 1'b0);
    run(50);
    check("R5 R2 accumulated swing flips", first_fall, 24);
    check("R9 strobe aligned hysteresis", edge_bad, 0);
  endtask

  initial begin
    t_reset();
    t_steps();
    t_short_pulse();
    t_min_pulse();
    t_burst();
    t_hysteresis();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule